// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Line Status

This block recovers asynchronous serial characters from a single input line. The line is resynchronised into the clock domain and sampled once per pulse of an external tick that runs at sixteen times the bit rate. Each character has a start bit, eight data bits sent least significant bit first, an optional parity bit and a stop bit. The receiver checks each character for parity, framing and break conditions and then stores it with its error tags in a sixteen-entry receive queue.

The oldest stored character is always shown on `rx_data`, and `data_ready` tells the reader that it is valid. A one-cycle `rd_data` strobe removes that character. A set of sticky status flags covers overrun, parity, framing and break. The tags of each character are merged into the flags at the moment that character reaches the head of the queue. A one-cycle `rd_status` strobe clears all four flags.

Top module: `uart_rx_lsr`

## Requirements
- R1: A falling line is taken as a start bit only if it is still low at the 8th baud tick, counting the first tick that saw it low. Otherwise it is ignored as a glitch. After a valid start, the receiver samples 8 data bits least significant bit first, then a parity bit when `par_en` is 1, then the stop bit, each 16 ticks after the previous sample.
- R2: `data_ready` is 1 exactly while the queue holds at least one character, and `rx_data` then shows the oldest one. A `rd_data` pulse removes it. A `rd_data` pulse while the queue is empty has no effect.
- R3: The queue holds up to 16 characters and returns them in arrival order.
- R4: A character that completes while 16 are stored is dropped, the stored ones are unchanged, and `overrun` goes to 1 on the next clock.
- R5: A `rd_status` pulse clears `overrun`, `parity_err`, `framing_err` and `break_ind`. A character already reported does not set its flags again.
- R6: `par_sel` picks the expected parity bit: 00 gives odd parity over the data, 01 gives even parity, 10 gives a constant 1, and 11 gives a constant 0. A mismatch tags the character with a parity error, but only when `par_en` is 1.
- R7: A stop bit sampled low tags the character with a framing error. The receiver then treats that low sample as the middle of the next start bit and samples the next data bit 16 ticks later.
- R8: A character with all data bits 0, a low stop bit and, when parity is on, a low parity bit is tagged as a break and also as a framing error. After it, the receiver starts nothing until the line has returned high.
- R9: When a character becomes the oldest in the queue, its parity, framing and break tags are ORed into the matching sticky flags.
- R10: After reset, `data_ready` and all four status flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, asynchronous, idles high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| par_en | input | 1 | 1 when a parity bit follows the data |
| par_sel | input | 2 | Parity rule: 00 odd, 01 even, 10 always 1, 11 always 0 |
| rd_data | input | 1 | Pulse that removes the oldest character |
| rd_status | input | 1 | Pulse that clears the sticky flags |
| rx_data | output | 8 | Oldest stored character |
| data_ready | output | 1 | Queue not empty |
| overrun | output | 1 | Sticky: a character was dropped on a full queue |
| parity_err | output | 1 | Sticky: a head character failed parity |
| framing_err | output | 1 | Sticky: a head character had a low stop bit |
| break_ind | output | 1 | Sticky: a head character was a break |

## Verification
The embedded properties check several rules on every cycle. A completed character on a full queue must raise `overrun` one clock later. A status read with no new event must leave all flags clear. A new head's tags must appear in the flags. The queue count must stay within its depth. A framing error must put the receiver straight into data sampling. A break must hold the receiver idle while the line stays low. Other behaviours can only be shown by the bench's line waveforms: glitch rejection, the bit order, each of the four parity rules, resynchronisation on a following character sent without a gap, the ordering of sixteen stored characters with the seventeenth dropped, and that a read on an empty queue does nothing.

// File: rtl/urx_pkg.sv
package urx_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_ONE   = 2'b10,
    PAR_ZERO  = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  function automatic logic want_parity(input logic [1:0] mode,
                                       input logic [CHAR_W-1:0] d);
    case (mode)
      PAR_ODD:  want_parity = ~(^d);
      PAR_EVEN: want_parity = ^d;
      PAR_ONE:  want_parity = 1'b1;
      default:  want_parity = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int   STAGES   = 2,
  parameter logic INIT_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{INIT_VAL}};
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{INIT_VAL}};
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/urx_deframer.sv
module urx_deframer
  import urx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       line,
  input  logic       par_en,
  input  logic [1:0] par_sel,
  output logic       char_valid,
  output rx_entry_t  char_out
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(CHAR_W);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OVS / 2 - 1);
  localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(CHAR_W - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK
  } rx_state_e;

  rx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  bidx;
  logic [CHAR_W-1:0] shreg;
  logic              pbit;
  logic              stop_low, is_brk, bad_par;

  assign stop_low = ~line;
  assign bad_par  = par_en && (pbit != want_parity(par_sel, shreg));
  assign is_brk   = (shreg == '0) && stop_low && (!par_en || !pbit);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      bidx       <= '0;
      shreg      <= '0;
      pbit       <= 1'b0;
      char_valid <= 1'b0;
      char_out   <= '0;
    end else begin
      char_valid <= 1'b0;
      case (st)
        S_IDLE: if (tick && !line) begin
          st  <= S_START;
          cnt <= CNT_W'(1);
        end
        S_START: if (tick) begin
          if (cnt == MID_TICK) begin
            cnt  <= '0;
            bidx <= '0;
            st   <= line ? S_IDLE : S_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: if (tick) begin
          if (cnt == LAST_TICK) begin
            cnt   <= '0;
            shreg <= {line, shreg[CHAR_W-1:1]};
            if (bidx == LAST_BIT) st <= par_en ? S_PAR : S_STOP;
            else                  bidx <= bidx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PAR: if (tick) begin
          if (cnt == LAST_TICK) begin
            cnt  <= '0;
            pbit <= line;
            st   <= S_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: if (tick) begin
          if (cnt == LAST_TICK) begin
            cnt        <= '0;
            bidx       <= '0;
            char_valid <= 1'b1;
            char_out   <= '{brk: is_brk, frm: stop_low, par: bad_par, data: shreg};
            if (is_brk)        st <= S_BRK;
            else if (stop_low) st <= S_DATA;
            else               st <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_BRK: if (line) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    char_valid |=> !char_valid);

  a_r7_resync_to_data: assert property (@(posedge clk) disable iff (rst)
    (char_valid && char_out.frm && !char_out.brk) |-> (st == S_DATA && cnt == '0));

  a_r8_break_holds_idle: assert property (@(posedge clk) disable iff (rst)
    (st == S_BRK && !line) |=> (st == S_BRK));

  a_r8_break_is_framing: assert property (@(posedge clk) disable iff (rst)
    (char_valid && char_out.brk) |-> (char_out.frm && char_out.data == '0));

endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wr_word,
  output logic [WIDTH-1:0] rd_word,
  output logic             nonempty,
  output logic             full,
  output logic             head_new
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP      = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt, cnt_nx;
  logic             wr_en, rd_en;

  assign wr_en  = push && !full;
  assign rd_en  = pop && nonempty;
  assign cnt_nx = cnt + CW'(wr_en) - CW'(rd_en);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_word;
  end

  assign rd_word = mem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      nonempty <= 1'b0;
      full     <= 1'b0;
      head_new <= 1'b0;
    end else begin
      if (wr_en) wp <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
      cnt      <= cnt_nx;
      nonempty <= (cnt_nx != '0);
      full     <= (cnt_nx == CAP);
      head_new <= (wr_en && (cnt == '0 || (rd_en && cnt == CW'(1))))
               || (rd_en && cnt > CW'(1));
    end
  end

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= CAP);

  a_r4_full_keeps: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> full);

  a_r2_empty_pop_noop: assert property (@(posedge clk) disable iff (rst)
    (!nonempty && pop && !push) |=> !nonempty);

endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import urx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  input  logic              baud_tick,
  input  logic              par_en,
  input  logic [1:0]        par_sel,
  input  logic              rd_data,
  input  logic              rd_status,
  output logic [CHAR_W-1:0] rx_data,
  output logic              data_ready,
  output logic              overrun,
  output logic              parity_err,
  output logic              framing_err,
  output logic              break_ind
);

  localparam int ENTRY_W = $bits(rx_entry_t);

  logic       line_s;
  logic       char_valid;
  rx_entry_t  char_new, head;
  logic       fifo_full, head_new, ovf_evt;
  logic [ENTRY_W-1:0] head_vec;

  urx_sync #(.STAGES(SYNC_STAGES), .INIT_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(line_s)
  );

  urx_deframer #(.OVS(OVS)) u_deframe (
    .clk(clk), .rst(rst), .tick(baud_tick), .line(line_s),
    .par_en(par_en), .par_sel(par_sel),
    .char_valid(char_valid), .char_out(char_new)
  );

  urx_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(char_valid), .pop(rd_data),
    .wr_word(char_new), .rd_word(head_vec),
    .nonempty(data_ready), .full(fifo_full), .head_new(head_new)
  );

  assign head    = rx_entry_t'(head_vec);
  assign rx_data = head.data;
  assign ovf_evt = char_valid && fifo_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      overrun     <= 1'b0;
      parity_err  <= 1'b0;
      framing_err <= 1'b0;
      break_ind   <= 1'b0;
    end else begin
      overrun     <= (overrun     && !rd_status) || ovf_evt;
      parity_err  <= (parity_err  && !rd_status) || (head_new && head.par);
      framing_err <= (framing_err && !rd_status) || (head_new && head.frm);
      break_ind   <= (break_ind   && !rd_status) || (head_new && head.brk);
    end
  end

  a_r4_overrun_sets: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> overrun);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_status && !head_new && !ovf_evt)
      |=> !(overrun || parity_err || framing_err || break_ind));

  a_r9_head_parity: assert property (@(posedge clk) disable iff (rst)
    (head_new && head.par) |=> parity_err);

  a_r9_head_break: assert property (@(posedge clk) disable iff (rst)
    (head_new && head.brk) |=> (break_ind && framing_err));

  a_r2_ready_after_store: assert property (@(posedge clk) disable iff (rst)
    (char_valid && !fifo_full) |=> data_ready);

endmodule

// File: tb/uart_rx_lsr_test.sv
module uart_rx_lsr_test;

  localparam int TPER   = 4;
  localparam int BITCLK = 16 * TPER;
  localparam int DEPTH  = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       baud_tick = 1'b0;
  logic       par_en = 1'b0;
  logic [1:0] par_sel = 2'b00;
  logic       rd_data = 1'b0;
  logic       rd_status = 1'b0;
  logic [7:0] rx_data;
  logic       data_ready, overrun, parity_err, framing_err, break_ind;

  int checks = 0;
  int fails  = 0;
  bit sync_ok = 1'b0;
  int tcnt = 0;

  typedef struct packed { logic [7:0] d; logic pe; logic fe; logic bi; } exp_t;
  exp_t q[$];
  bit e_ovr, e_pe, e_fe, e_bi;

  uart_rx_lsr uut (
    .clk(clk), .rst(rst), .rxd(rxd), .baud_tick(baud_tick),
    .par_en(par_en), .par_sel(par_sel), .rd_data(rd_data), .rd_status(rd_status),
    .rx_data(rx_data), .data_ready(data_ready), .overrun(overrun),
    .parity_err(parity_err), .framing_err(framing_err), .break_ind(break_ind)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst) begin
      tcnt <= 0; baud_tick <= 1'b0;
    end else begin
      tcnt      <= (tcnt == TPER - 1) ? 0 : tcnt + 1;
      baud_tick <= (tcnt == TPER - 1);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic par_of(input logic [1:0] m, input logic [7:0] d);
    if (m == 2'b00) return ~(^d);
    if (m == 2'b01) return ^d;
    return (m == 2'b10);
  endfunction

  function automatic void take_tags(input exp_t e);
    e_pe |= e.pe; e_fe |= e.fe; e_bi |= e.bi;
  endfunction

  function automatic void m_push(input logic [7:0] d, input bit pe, input bit fe, input bit bi);
    exp_t e;
    e = '{d: d, pe: pe, fe: fe, bi: bi};
    if (q.size() >= DEPTH) e_ovr = 1'b1;
    else begin
      q.push_back(e);
      if (q.size() == 1) take_tags(e);
    end
  endfunction

  function automatic void m_pop();
    if (q.size() > 0) begin
      void'(q.pop_front());
      if (q.size() > 0) take_tags(q[0]);
    end
  endfunction

  // every-cycle comparison with the model while the bench is idle
  always @(negedge clk) begin
    if (sync_ok) begin
      chk("R2", "data_ready", int'(data_ready), int'(q.size() != 0));
      if (q.size() != 0) chk("R3", "rx_data", int'(rx_data), int'(q[0].d));
      chk("R4", "overrun", int'(overrun), int'(e_ovr));
      chk("R9", "parity_err", int'(parity_err), int'(e_pe));
      chk("R9", "framing_err", int'(framing_err), int'(e_fe));
      chk("R9", "break_ind", int'(break_ind), int'(e_bi));
    end
  end

  task automatic settle();
    repeat (4) @(negedge clk);
    sync_ok = 1'b1;
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input bit corrupt);
    sync_ok = 1'b0;
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (par_en) drive_bit(par_of(par_sel, d) ^ corrupt);
    drive_bit(1'b1);
    m_push(d, par_en && corrupt, 1'b0, 1'b0);
    settle();
  endtask

  task automatic read_char(input string req);
    sync_ok = 1'b0;
    chk(req, "ready before read", int'(data_ready), 1);
    chk(req, "head character", int'(rx_data), int'(q[0].d));
    rd_data = 1'b1;
    @(negedge clk);
    rd_data = 1'b0;
    m_pop();
    settle();
  endtask

  task automatic read_status(input string req);
    sync_ok = 1'b0;
    chk(req, "overrun at read", int'(overrun), int'(e_ovr));
    chk(req, "parity_err at read", int'(parity_err), int'(e_pe));
    chk(req, "framing_err at read", int'(framing_err), int'(e_fe));
    chk(req, "break_ind at read", int'(break_ind), int'(e_bi));
    rd_status = 1'b1;
    @(negedge clk);
    rd_status = 1'b0;
    e_ovr = 0; e_pe = 0; e_fe = 0; e_bi = 0;
    settle();
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R10 reset state
    chk("R10", "data_ready", int'(data_ready), 0);
    chk("R10", "flags", int'({overrun, parity_err, framing_err, break_ind}), 0);
    settle();

    // R1 basic frames, LSB first, no parity
    send_char(8'h55, 1'b0);
    send_char(8'hA3, 1'b0);
    read_char("R1");
    read_char("R1");

    // R2 read strobe on empty queue
    sync_ok = 1'b0;
    rd_data = 1'b1;
    @(negedge clk);
    rd_data = 1'b0;
    settle();
    chk("R2", "empty read ignored", int'(data_ready), 0);
    send_char(8'h3C, 1'b0);
    read_char("R2");

    // R1 short glitch rejected
    sync_ok = 1'b0;
    rxd = 1'b0;
    repeat (3 * TPER) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    settle();
    chk("R1", "glitch gives no character", int'(data_ready), 0);

    // R6 four parity rules, one good and one corrupted character each
    par_en = 1'b1;
    for (int m = 0; m < 4; m++) begin
      par_sel = 2'(m);
      send_char(8'h5A, 1'b0);
      send_char(8'h07, 1'b1);
      read_status("R6");
      read_char("R6");
      chk("R6", "bad parity flagged at head", int'(parity_err), 1);
      read_status("R5");
      chk("R5", "parity_err cleared", int'(parity_err), 0);
      read_char("R6");
    end

    // R7 framing error then back-to-back character
    par_en = 1'b0;
    sync_ok = 1'b0;
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(1'(8'h81 >> i));
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(1'(8'h4D >> i));
    drive_bit(1'b1);
    drive_bit(1'b1);
    m_push(8'h81, 1'b0, 1'b1, 1'b0);
    m_push(8'h4D, 1'b0, 1'b0, 1'b0);
    settle();
    chk("R7", "framing_err", int'(framing_err), 1);
    read_status("R7");
    read_char("R7");
    read_char("R7");
    chk("R7", "only two characters", int'(data_ready), 0);

    // R8 break with forced-zero parity, line held low afterwards
    par_en = 1'b1;
    par_sel = 2'b11;
    sync_ok = 1'b0;
    for (int i = 0; i < 14; i++) drive_bit(1'b0);
    drive_bit(1'b1);
    drive_bit(1'b1);
    m_push(8'h00, 1'b0, 1'b1, 1'b1);
    settle();
    chk("R8", "break_ind", int'(break_ind), 1);
    send_char(8'h66, 1'b0);
    read_status("R8");
    read_char("R8");
    read_char("R8");
    chk("R8", "nothing extra during low line", int'(data_ready), 0);

    // R3 and R4 fill past capacity
    par_en = 1'b0;
    for (int i = 0; i < DEPTH + 1; i++) send_char(8'(8'h10 + i), 1'b0);
    chk("R4", "overrun after drop", int'(overrun), 1);
    read_status("R5");
    chk("R5", "overrun cleared", int'(overrun), 0);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3", "order", int'(rx_data), 8'h10 + i);
      read_char("R3");
    end
    chk("R4", "dropped character absent", int'(data_ready), 0);

    sync_ok = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule